// File: doc/BRIEF.md
# Multi-Sector Transfer Interrupt Pacer

This block belongs to the command side of a disk-style storage device. It decides when the device raises its host interrupt and its data-request signals during multi-sector read, write and verify transfers. A command arrives as an opcode together with the value of the sector count register. A media engine elsewhere pulses a strobe each time it finishes fetching or committing one sector. The host-side buffer logic pulses a second strobe when the host has emptied or filled the sector buffer. This block does not move data and does not own the buffer.

The pacer keeps a sectors-until-interrupt counter and a count of the sectors still to go. The command type sets the interrupt spacing: one interrupt per sector, one per programmed block, or a single interrupt when the whole command finishes. A verify command chains sector fetches internally, with no host data phase. A separate opcode programs the block size that multiple-mode reads use.

Top module: `xfer_irq_pacer`

## Requirements
- R1: After reset, irq, drq, dmarq, bsy and fetch_req are all low, and the programmed block count is 1.
- R2: The sectors-until-interrupt counter is loaded with 1 when a command starts with opcode 0x20/0x21 (read), 0xC4 (read multiple), 0x30/0x31 (write) or 0xC5 (write multiple). It is loaded with the sector count when the opcode is 0xC8 (read DMA), 0xCA (write DMA) or 0x40/0x41 (verify), so those commands interrupt only after their final sector.
- R3: When a sector completes (sector_done in the fetch phase), the counter decrements. irq is raised on that same clock edge if the counter reaches 0 or if this was the last remaining sector.
- R4: When that interrupt fires, the counter reloads with the programmed block count for opcode 0xC4 and with 1 for every other opcode.
- R5: Opcode 0xC6 copies sec_count into the block count and raises irq on the edge that accepts the command. No transfer starts.
- R6: For a verify command, a completed sector issues fetch_req for the next sector on the same edge. drq and dmarq stay low for the whole command.
- R7: For the other read commands, a completed sector sets drq. dmarq is set together with drq only for opcode 0xC8.
- R8: A write command sets drq on the edge that accepts it. Opcode 0xCA also sets dmarq on that edge.
- R9: host_drained during the data phase clears drq and dmarq on that edge. If a sector still has to be fetched or committed, it also issues a one-cycle fetch_req on that edge.
- R10: bsy is high while a sector fetch or commit is outstanding (from fetch_req until sector_done). It falls on the same edge that raises drq or irq, and it is never high together with drq.
- R11: A sector count of 0 means 256 sectors.
- R12: irq_ack clears irq, unless an interrupt is raised on the same edge. Accepting any command clears irq, drq and dmarq. An opcode not listed above leaves the block idle with every output low.
- R13: After the last sector, the block returns to idle and issues no further fetch_req.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle strobe: the command register was written |
| cmd_op | input | 8 | Command opcode |
| sec_count | input | SEC_W | Sector count register value at command time |
| sector_done | input | 1 | Media finished fetching or committing one sector |
| host_drained | input | 1 | Host finished its buffer transfer for the current sector |
| irq_ack | input | 1 | Host status read, which acknowledges the interrupt |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | Data request status |
| dmarq | output | 1 | DMA request |
| bsy | output | 1 | Busy status |
| fetch_req | output | 1 | One-cycle request to fetch or commit the next sector |

## Verification
Some properties are checked on every cycle. bsy and drq are never high together. dmarq never appears without drq. A verify command never raises drq. A drain always drops drq on the next cycle. irq rises only on a command or a sector completion. An acknowledge with no competing event clears irq.

Other behaviours only the bench scenarios can show. These are the spacing of interrupts that depends on the command: per sector, per block with the reload after the first sector, or once per command. They also include the 256-sector reading of a zero count, and the exact edge on which each output changes.

// File: rtl/xfer_pacer_pkg.sv
`timescale 1ns/1ps
package xfer_pacer_pkg;

    localparam int OP_W = 8;

    localparam logic [OP_W-1:0] OP_RD       = 8'h20;
    localparam logic [OP_W-1:0] OP_RD_NR    = 8'h21;
    localparam logic [OP_W-1:0] OP_WR       = 8'h30;
    localparam logic [OP_W-1:0] OP_WR_NR    = 8'h31;
    localparam logic [OP_W-1:0] OP_VFY      = 8'h40;
    localparam logic [OP_W-1:0] OP_VFY_NR   = 8'h41;
    localparam logic [OP_W-1:0] OP_RD_MULTI = 8'hC4;
    localparam logic [OP_W-1:0] OP_WR_MULTI = 8'hC5;
    localparam logic [OP_W-1:0] OP_SET_BLK  = 8'hC6;
    localparam logic [OP_W-1:0] OP_RD_DMA   = 8'hC8;
    localparam logic [OP_W-1:0] OP_WR_DMA   = 8'hCA;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_FETCH = 2'd1,
        PH_XFER  = 2'd2
    } phase_e;

    typedef struct packed {
        logic rd;          // host-read transfer with a data phase
        logic wr;          // host-write transfer
        logic vfy;         // internal chaining, no data phase
        logic dma;         // data phase also raises dmarq
        logic rd_multi;    // reload spacing with block count
        logic set_blk;     // program block count
        logic whole_cmd;   // counter starts at sector count
    } op_class_t;

endpackage

// File: rtl/xfer_op_decode.sv
`timescale 1ns/1ps
module xfer_op_decode
    import xfer_pacer_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_class_t       cls
);

    always_comb begin
        cls = '0;
        case (op)
            OP_RD, OP_RD_NR:     cls.rd = 1'b1;
            OP_RD_MULTI: begin
                cls.rd       = 1'b1;
                cls.rd_multi = 1'b1;
            end
            OP_RD_DMA: begin
                cls.rd        = 1'b1;
                cls.dma       = 1'b1;
                cls.whole_cmd = 1'b1;
            end
            OP_VFY, OP_VFY_NR: begin
                cls.vfy       = 1'b1;
                cls.whole_cmd = 1'b1;
            end
            OP_WR, OP_WR_NR, OP_WR_MULTI: cls.wr = 1'b1;
            OP_WR_DMA: begin
                cls.wr        = 1'b1;
                cls.dma       = 1'b1;
                cls.whole_cmd = 1'b1;
            end
            OP_SET_BLK:          cls.set_blk = 1'b1;
            default:             cls = '0;
        endcase
    end

endmodule

// File: rtl/xfer_irq_spacer.sv
`timescale 1ns/1ps
module xfer_irq_spacer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             step,
    input  logic             last,
    input  logic [CNT_W-1:0] reload_val,
    output logic             fire
);

    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    assign fire = step && ((cnt_q == ONE) || last);

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (step) begin
            cnt_d = fire ? reload_val : (cnt_q - ONE);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= ONE;
        else        cnt_q <= cnt_d;
    end

    // a zero counter would never reach its terminal value again
    AST_SPACER_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q != '0); // R4

endmodule

// File: rtl/xfer_irq_pacer.sv
`timescale 1ns/1ps
module xfer_irq_pacer
    import xfer_pacer_pkg::*;
#(
    parameter int SEC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [OP_W-1:0]  cmd_op,
    input  logic [SEC_W-1:0] sec_count,
    input  logic             sector_done,
    input  logic             host_drained,
    input  logic             irq_ack,
    output logic             irq,
    output logic             drq,
    output logic             dmarq,
    output logic             bsy,
    output logic             fetch_req
);

    localparam int               CNT_W = SEC_W + 1;
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(1) << SEC_W;
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    typedef struct packed {
        phase_e           phase;
        op_class_t        cls;
        logic [CNT_W-1:0] remain;
        logic [SEC_W-1:0] blk;
        logic             irq;
        logic             drq;
        logic             dmarq;
        logic             bsy;
        logic             fetch;
    } pacer_st_t;

    function automatic logic [CNT_W-1:0] widen(input logic [SEC_W-1:0] v);
        return (v == '0) ? FULL : {1'b0, v};
    endfunction

    pacer_st_t        st_d, st_q;
    op_class_t        dec_cls;
    logic             sp_load, sp_step, sp_last, sp_fire;
    logic [CNT_W-1:0] sp_load_val, sp_reload;

    xfer_op_decode u_dec (
        .op  (cmd_op),
        .cls (dec_cls)
    );

    xfer_irq_spacer #(.CNT_W(CNT_W)) u_spacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (sp_load),
        .load_val   (sp_load_val),
        .step       (sp_step),
        .last       (sp_last),
        .reload_val (sp_reload),
        .fire       (sp_fire)
    );

    assign sp_last   = (st_q.remain == ONE);
    assign sp_reload = st_q.cls.rd_multi ? widen(st_q.blk) : ONE;

    always_comb begin
        st_d        = st_q;
        st_d.fetch  = 1'b0;
        sp_load     = 1'b0;
        sp_load_val = ONE;
        sp_step     = 1'b0;

        if (irq_ack) st_d.irq = 1'b0;

        if (cmd_valid) begin
            st_d.irq    = 1'b0;
            st_d.drq    = 1'b0;
            st_d.dmarq  = 1'b0;
            st_d.bsy    = 1'b0;
            st_d.phase  = PH_IDLE;
            st_d.cls    = dec_cls;
            st_d.remain = widen(sec_count);
            sp_load     = 1'b1;
            sp_load_val = dec_cls.whole_cmd ? widen(sec_count) : ONE;
            if (dec_cls.set_blk) begin
                st_d.blk = sec_count;
                st_d.irq = 1'b1;
            end else if (dec_cls.rd || dec_cls.vfy) begin
                st_d.phase = PH_FETCH;
                st_d.bsy   = 1'b1;
                st_d.fetch = 1'b1;
            end else if (dec_cls.wr) begin
                st_d.phase = PH_XFER;
                st_d.drq   = 1'b1;
                st_d.dmarq = dec_cls.dma;
            end
        end else begin
            case (st_q.phase)
                PH_FETCH: begin
                    if (sector_done) begin
                        sp_step     = 1'b1;
                        st_d.bsy    = 1'b0;
                        st_d.remain = st_q.remain - ONE;
                        if (sp_fire) st_d.irq = 1'b1;
                        if (st_q.cls.vfy) begin
                            if (sp_last) begin
                                st_d.phase = PH_IDLE;
                            end else begin
                                st_d.bsy   = 1'b1;
                                st_d.fetch = 1'b1;
                            end
                        end else if (st_q.cls.wr && sp_last) begin
                            st_d.phase = PH_IDLE;
                        end else begin
                            st_d.phase = PH_XFER;
                            st_d.drq   = 1'b1;
                            st_d.dmarq = st_q.cls.dma;
                        end
                    end
                end
                PH_XFER: begin
                    if (host_drained) begin
                        st_d.drq   = 1'b0;
                        st_d.dmarq = 1'b0;
                        if (st_q.cls.wr || (st_q.remain != '0)) begin
                            st_d.phase = PH_FETCH;
                            st_d.bsy   = 1'b1;
                            st_d.fetch = 1'b1;
                        end else begin
                            st_d.phase = PH_IDLE;
                        end
                    end
                end
                default: st_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.phase <= PH_IDLE;
            st_q.blk   <= SEC_W'(1);
        end else begin
            st_q <= st_d;
        end
    end

    assign irq       = st_q.irq;
    assign drq       = st_q.drq;
    assign dmarq     = st_q.dmarq;
    assign bsy       = st_q.bsy;
    assign fetch_req = st_q.fetch;

    AST_DRQ_EXCL_BSY: assert property (@(posedge clk) disable iff (!rst_n)
        !(drq && bsy)); // R10

    AST_DMARQ_NEEDS_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        dmarq |-> drq); // R7

    AST_VERIFY_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cls.vfy |-> !drq); // R6

    AST_DRAIN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_XFER && host_drained && !cmd_valid) |=> !drq); // R9

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(cmd_valid) || $past(sector_done))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !cmd_valid && !sector_done) |=> !irq); // R12

endmodule

// File: tb/tb_xfer_irq_pacer.sv
`timescale 1ns/1ps
module tb_xfer_irq_pacer;

    localparam int SEC_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0;
    logic [7:0]       cmd_op = 8'h00;
    logic [SEC_W-1:0] sec_count = '0;
    logic             sector_done = 1'b0;
    logic             host_drained = 1'b0;
    logic             irq_ack = 1'b0;
    logic             irq, drq, dmarq, bsy, fetch_req;

    typedef struct {
        logic [4:0] exp;   // {irq, drq, dmarq, bsy, fetch_req}
        string      tag;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #10 clk = ~clk;

    xfer_irq_pacer #(.SEC_W(SEC_W)) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .sec_count    (sec_count),
        .sector_done  (sector_done),
        .host_drained (host_drained),
        .irq_ack      (irq_ack),
        .irq          (irq),
        .drq          (drq),
        .dmarq        (dmarq),
        .bsy          (bsy),
        .fetch_req    (fetch_req)
    );

    // driver: one clock cycle of stimulus plus the outputs expected after its edge
    task automatic cyc(input logic cv, input logic [7:0] op, input logic [7:0] sc,
                       input logic sd, input logic hd, input logic ak,
                       input logic [4:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        cmd_valid    = cv;
        cmd_op       = op;
        sec_count    = sc;
        sector_done  = sd;
        host_drained = hd;
        irq_ack      = ak;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: compares outputs a little after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [4:0] act;
                it  = sb_q.pop_front();
                act = {irq, drq, dmarq, bsy, fetch_req};
                n_vec++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: {irq,drq,dmarq,bsy,fetch} actual=%b expected=%b",
                             it.tag, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        cyc(0, 8'h00, 8'd0, 0, 0, 0, 5'b00000, "R1 reset");

        // read sectors, count 2: interrupt on every sector
        cyc(1, 8'h20, 8'd2, 0, 0, 0, 5'b00011, "R10 read start busy+fetch");
        cyc(0, 8'h00, 8'd0, 0, 0, 0, 5'b00010, "R10 busy while fetching");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11000, "R7 R3 sector 1 drq+irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b10011, "R9 drain fetches next");
        cyc(0, 8'h00, 8'd0, 0, 0, 1, 5'b00010, "R12 ack clears irq");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11000, "R3 last sector irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 1, 5'b00000, "R13 read ends idle");
        cyc(0, 8'h00, 8'd0, 0, 0, 0, 5'b00000, "R13 no further fetch");

        // read DMA, count 3: one interrupt for the whole command
        cyc(1, 8'hC8, 8'd3, 0, 0, 0, 5'b00011, "R2 dma read start");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b01100, "R7 dmarq with drq, no irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 drain clears dmarq");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b01100, "R2 second sector no irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 drain 2");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11100, "R2 final sector irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 1, 5'b00000, "R13 dma read ends");

        // program block count 2
        cyc(1, 8'hC6, 8'd2, 0, 0, 0, 5'b10000, "R5 set block irq");
        cyc(0, 8'h00, 8'd0, 0, 0, 1, 5'b00000, "R12 ack after set block");

        // read multiple, count 5, block 2: irq after sectors 1, 3, 5
        cyc(1, 8'hC4, 8'd5, 0, 0, 0, 5'b00011, "R4 multi start");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11000, "R4 first sector irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 1, 5'b00011, "R9 multi drain 1");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b01000, "R4 sector 2 inside block");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 multi drain 2");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11000, "R4 sector 3 ends block");
        cyc(0, 8'h00, 8'd0, 0, 1, 1, 5'b00011, "R9 multi drain 3");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b01000, "R4 sector 4 inside block");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 multi drain 4");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11000, "R3 sector 5 last forces irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 1, 5'b00000, "R13 multi ends");

        // verify, count 3: internal chaining, one irq at the end
        cyc(1, 8'h40, 8'd3, 0, 0, 0, 5'b00011, "R6 verify start");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b00011, "R6 verify chains sector 2");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b00011, "R6 verify chains sector 3");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b10000, "R6 verify done irq no drq");
        cyc(0, 8'h00, 8'd0, 0, 0, 1, 5'b00000, "R12 ack after verify");

        // write DMA, count 2
        cyc(1, 8'hCA, 8'd2, 0, 0, 0, 5'b01100, "R8 dma write drq+dmarq at start");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 write drain commits");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b01100, "R2 write sector 1 no irq");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 write drain 2");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b10000, "R13 write done irq idle");
        cyc(0, 8'h00, 8'd0, 0, 0, 1, 5'b00000, "R12 ack after write");

        // write sectors, count 1: no dmarq
        cyc(1, 8'h30, 8'd1, 0, 0, 0, 5'b01000, "R8 pio write drq only");
        cyc(0, 8'h00, 8'd0, 0, 1, 0, 5'b00011, "R9 pio write commit");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b10000, "R3 pio write irq");
        cyc(0, 8'h00, 8'd0, 0, 0, 1, 5'b00000, "R12 ack pio write");

        // verify with count 0 = 256 sectors
        cyc(1, 8'h41, 8'd0, 0, 0, 0, 5'b00011, "R11 verify 256 start");
        for (int i = 0; i < 255; i++)
            cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b00011, "R11 no irq before sector 256");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b10000, "R11 irq at sector 256");

        // command clears irq; unknown opcode leaves idle
        cyc(0, 8'h00, 8'd0, 0, 0, 0, 5'b10000, "R11 irq held");
        cyc(1, 8'h99, 8'd4, 0, 0, 0, 5'b00000, "R12 unknown opcode clears irq");
        cyc(0, 8'h00, 8'd0, 1, 1, 0, 5'b00000, "R12 strobes ignored when idle");
        cyc(1, 8'hC8, 8'd1, 0, 0, 0, 5'b00011, "R2 dma read count 1");
        cyc(0, 8'h00, 8'd0, 1, 0, 0, 5'b11100, "R3 single sector irq");
        cyc(1, 8'h20, 8'd1, 0, 0, 0, 5'b00011, "R12 new command clears irq drq dmarq");
        cyc(0, 8'h00, 8'd0, 1, 0, 1, 5'b11000, "R12 irq set wins over ack");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule